// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the even parity bit that travels with a 32-bit multiplexed address/data bus and its 4-bit command/byte-enable lanes. When the surrounding interface logic drives the bus, the block turns the covered word into a parity bit and presents it, with an output enable, on the clock after that word.

When the interface receives a word, it marks the completing edge as a check phase. This applies to read data taken in as an initiator and to write data taken in as a target. The block stores the parity it expects and compares it, one edge later, against the parity bit seen on the bus.

A mismatch always sets a sticky detected-error flag. Software clears that flag with a one-cycle clear strobe. If error reporting is enabled, the mismatch also pulls an active-low parity-error output low for one clock. The bus sequencing that decides which phases are driven or received lives outside this block, and so does any escalation of errors to a system-level signal.

Top module: `bus_parity_unit`

## Requirements
- R1: The generated parity bit `par_o` makes the count of ones across `ad_i[31:0]`, `cbe_i[3:0]` and `par_o` even.
- R2: `par_oe_o` is high for exactly the clock after an edge that samples `drive_i` high, and `par_o` then carries the parity of the word sampled on that edge. When not enabled, `par_o` is 0.
- R3: A check phase is an edge where `phase_done_i` and `rx_i` are high and `drive_i` is low. Its expected parity is taken from `ad_i`/`cbe_i` on that edge and compared with `par_i` sampled on the next edge.
- R4: A mismatch with `perr_en_i` high on the comparing edge drives `perr_n_o` low for one clock, starting at the second edge after the check phase.
- R5: With `perr_en_i` low on the comparing edge, a mismatch leaves `perr_n_o` high but still sets `dpe_o`.
- R6: `dpe_o` rises on the second edge after a mismatching check phase and stays high until an edge that samples `dpe_clr_i` high. A set on the same edge as a clear wins.
- R7: No comparison is made for idle edges (`phase_done_i` low) or for edges where `drive_i` is high, whatever `par_i` does next.
- R8: After reset `perr_n_o` is 1, and `dpe_o`, `par_o` and `par_oe_o` are 0.
- R9: Check phases on consecutive edges are judged independently, so two mismatching phases in a row give two consecutive low clocks on `perr_n_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus value seen this cycle |
| cbe_i | input | 4 | Command/byte-enable value seen this cycle |
| drive_i | input | 1 | The interface drives `ad_i`/`cbe_i` this cycle |
| rx_i | input | 1 | This cycle's word is received data subject to checking |
| phase_done_i | input | 1 | The current phase completes on this edge |
| par_i | input | 1 | Parity bit sampled from the bus |
| perr_en_i | input | 1 | Parity-error reporting enable from the command register |
| dpe_clr_i | input | 1 | Write-one-to-clear strobe for the sticky flag |
| par_o | output | 1 | Generated parity bit, one clock behind its word |
| par_oe_o | output | 1 | Output enable for `par_o` |
| perr_n_o | output | 1 | Active-low parity-error pulse |
| dpe_o | output | 1 | Sticky detected-parity-error flag |

## Verification
A stale or misplaced expected-parity register would show up two clocks after a received phase. It appears as a spurious or missing `perr_n_o` pulse and as a wrong `dpe_o`. A check-qualification fault, which fails to mask idle or driven phases, would likewise show up as an error pulse two clocks after an idle or driven edge followed by deliberately bad parity. A generator fault is visible one clock after the word, on `par_o` or `par_oe_o`. Clear-versus-set priority is exposed by asserting the clear strobe on the very edge where a new mismatch lands.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;
  localparam int unsigned FOLD_W = 64;

  typedef struct packed {
    logic armed;
    logic want;
  } chk_slot_t;

  // Odd-weight test: returns 1 when the vector holds an odd number of ones.
  function automatic logic odd_weight(input logic [FOLD_W-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < FOLD_W; i++) acc = acc ^ v[i];
    return acc;
  endfunction
endpackage

// File: rtl/bus_parity_gen.sv
module bus_parity_gen #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             drive_i,
  output logic             par_o,
  output logic             par_oe_o
);
  import bus_parity_pkg::*;
  localparam int unsigned WORD_W = AD_W + CBE_W;

  logic [WORD_W-1:0] word;
  logic              word_par;

  assign word     = {ad_i, cbe_i};
  assign word_par = odd_weight(FOLD_W'(word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= drive_i ? word_par : 1'b0;
      par_oe_o <= drive_i;
    end
  end
endmodule

// File: rtl/bus_parity_chk.sv
module bus_parity_chk #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             capture_i,
  input  logic             par_i,
  output logic             pend_o,
  output logic             mismatch_o
);
  import bus_parity_pkg::*;
  localparam int unsigned WORD_W = AD_W + CBE_W;

  chk_slot_t         slot_q;
  logic [WORD_W-1:0] word;

  assign word = {ad_i, cbe_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      slot_q.armed <= capture_i;
      slot_q.want  <= capture_i ? odd_weight(FOLD_W'(word)) : 1'b0;
    end
  end

  assign pend_o     = slot_q.armed;
  assign mismatch_o = slot_q.armed & (par_i ^ slot_q.want);
endmodule

// File: rtl/bus_parity_err.sv
module bus_parity_err (
  input  logic clk,
  input  logic rst_n,
  input  logic mismatch_i,
  input  logic perr_en_i,
  input  logic dpe_clr_i,
  output logic seen_o,
  output logic perr_n_o,
  output logic dpe_o
);
  logic seen_q;
  logic report_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      report_q <= 1'b0;
      perr_n_o <= 1'b1;
      dpe_o    <= 1'b0;
    end else begin
      seen_q   <= mismatch_i;
      report_q <= mismatch_i & perr_en_i;
      perr_n_o <= ~report_q;
      if (seen_q)         dpe_o <= 1'b1;
      else if (dpe_clr_i) dpe_o <= 1'b0;
    end
  end

  assign seen_o = seen_q;
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             drive_i,
  input  logic             rx_i,
  input  logic             phase_done_i,
  input  logic             par_i,
  input  logic             perr_en_i,
  input  logic             dpe_clr_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_n_o,
  output logic             dpe_o
);
  // Named internal events, visible to the bound checker.
  logic cap_fire;
  logic chk_pend;
  logic mismatch_w;
  logic seen_w;

  assign cap_fire = phase_done_i & rx_i & ~drive_i;

  bus_parity_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .ad_i     (ad_i),
    .cbe_i    (cbe_i),
    .drive_i  (drive_i),
    .par_o    (par_o),
    .par_oe_o (par_oe_o)
  );

  bus_parity_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad_i       (ad_i),
    .cbe_i      (cbe_i),
    .capture_i  (cap_fire),
    .par_i      (par_i),
    .pend_o     (chk_pend),
    .mismatch_o (mismatch_w)
  );

  bus_parity_err u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .mismatch_i (mismatch_w),
    .perr_en_i  (perr_en_i),
    .dpe_clr_i  (dpe_clr_i),
    .seen_o     (seen_w),
    .perr_n_o   (perr_n_o),
    .dpe_o      (dpe_o)
  );
endmodule

// File: rtl/bus_parity_unit_chk.sv
module bus_parity_unit_chk #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AD_W-1:0]  ad_i,
  input logic [CBE_W-1:0] cbe_i,
  input logic             drive_i,
  input logic             perr_en_i,
  input logic             dpe_clr_i,
  input logic             par_o,
  input logic             par_oe_o,
  input logic             perr_n_o,
  input logic             dpe_o,
  input logic             cap_fire,
  input logic             chk_pend,
  input logic             mismatch_w,
  input logic             seen_w
);
  // R1
  even_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_i |=> (^{$past(ad_i), $past(cbe_i), par_o}) == 1'b0);

  // R2
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_i |=> par_oe_o);

  // R2
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_i |=> !par_oe_o && !par_o);

  // R7
  no_stray_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> !chk_pend && !mismatch_w);

  // R4
  perr_after_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch_w && perr_en_i) |-> ##2 !perr_n_o);

  // R5
  perr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch_w && !perr_en_i) |-> ##2 perr_n_o);

  // R6
  dpe_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_w |-> ##2 dpe_o);

  // R6
  dpe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dpe_o && !dpe_clr_i) |=> dpe_o);

  // R6
  dpe_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dpe_o) |-> $past(seen_w));
endmodule

bind bus_parity_unit bus_parity_unit_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .ad_i       (ad_i),
  .cbe_i      (cbe_i),
  .drive_i    (drive_i),
  .perr_en_i  (perr_en_i),
  .dpe_clr_i  (dpe_clr_i),
  .par_o      (par_o),
  .par_oe_o   (par_oe_o),
  .perr_n_o   (perr_n_o),
  .dpe_o      (dpe_o),
  .cap_fire   (cap_fire),
  .chk_pend   (chk_pend),
  .mismatch_w (mismatch_w),
  .seen_w     (seen_w)
);

// File: tb/bus_parity_unit_test.sv
module bus_parity_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        drv = 1'b0, rx = 1'b0, done = 1'b0, par_in = 1'b0;
  logic        en = 1'b0, clr = 1'b0;
  logic        par_o, par_oe_o, perr_n_o, dpe_o;

  int vectors = 0;
  int misses = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int    due;
    int    which;   // 0 par, 1 oe, 2 perr_n, 3 dpe
    logic  val;
    string tag;
  } exp_t;
  exp_t sb[$];

  // bench-side model state
  logic m_pend = 0, m_want = 0, m_mis = 0, m_rep = 0, m_dpe = 0;
  logic nxt_good = 0;

  bus_parity_unit uut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe), .drive_i(drv),
    .rx_i(rx), .phase_done_i(done), .par_i(par_in), .perr_en_i(en),
    .dpe_clr_i(clr), .par_o(par_o), .par_oe_o(par_oe_o),
    .perr_n_o(perr_n_o), .dpe_o(dpe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic ones_odd(input logic [31:0] a, input logic [3:0] b);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) if (a[i]) n++;
    for (int i = 0; i < 4; i++) if (b[i]) n++;
    return (n % 2) == 1;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%b expected=%b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Driver: one edge of stimulus; par_i belongs to the previous check phase.
  task automatic step(input logic [31:0] a, input logic [3:0] b, input logic d,
                      input logic r, input logic dn, input logic p,
                      input logic e, input logic c, input string tag);
    int   edge_no;
    logic new_perr, new_dpe, mis_now, g;
    @(negedge clk);
    ad = a; cbe = b; drv = d; rx = r; done = dn; par_in = p; en = e; clr = c;
    edge_no = cyc + 1;
    g = ones_odd(a, b);
    new_perr = !m_rep;
    new_dpe  = m_mis ? 1'b1 : (c ? 1'b0 : m_dpe);
    mis_now  = m_pend && (p != m_want);
    m_rep  = mis_now && e;
    m_mis  = mis_now;
    m_dpe  = new_dpe;
    m_pend = dn && r && !d;
    m_want = g;
    nxt_good = g;
    sb.push_back('{edge_no, 0, d ? g : 1'b0, "R1"});
    sb.push_back('{edge_no, 1, d, "R2"});
    sb.push_back('{edge_no, 2, new_perr, tag});
    sb.push_back('{edge_no, 3, new_dpe, tag});
  endtask

  // Monitor: compares results due at this cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t it;
      it = sb.pop_front();
      case (it.which)
        0: check(it.tag, "par_o", par_o, it.val);
        1: check(it.tag, "par_oe_o", par_oe_o, it.val);
        2: check(it.tag, "perr_n_o", perr_n_o, it.val);
        default: check(it.tag, "dpe_o", dpe_o, it.val);
      endcase
    end
  end

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, '0, 0, 0, 0, 0, en, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", "perr_n_o", perr_n_o, 1'b1);
    check("R8", "dpe_o", dpe_o, 1'b0);
    check("R8", "par_o", par_o, 1'b0);
    check("R8", "par_oe_o", par_oe_o, 1'b0);
    rst_n = 1'b1;

    // R1/R2: driven words of several shapes
    step(32'h0000_0000, 4'h0, 1, 0, 1, 0, 1, 0, "R2");
    step(32'hFFFF_FFFF, 4'hF, 1, 0, 1, 0, 1, 0, "R1");
    step(32'hA5A5_0001, 4'h7, 1, 0, 1, 0, 1, 0, "R1");
    step(32'h8000_0000, 4'h0, 1, 0, 0, 0, 1, 0, "R1");
    step(32'h1234_5678, 4'h2, 0, 0, 0, 0, 1, 0, "R2");
    idle(2, "R2");

    // R3: received phase with correct parity -> no error
    step(32'hDEAD_BEEF, 4'h3, 0, 1, 1, 0, 1, 0, "R3");
    step('0, '0, 0, 0, 0, nxt_good, 1, 0, "R3");
    idle(3, "R3");

    // R4: received phase with wrong parity -> one-clock pulse, dpe sets (R6)
    step(32'h0F0F_0F0F, 4'h1, 0, 1, 1, 0, 1, 0, "R4");
    step('0, '0, 0, 0, 0, !nxt_good, 1, 0, "R4");
    idle(3, "R4");

    // R6: clear the sticky flag
    step('0, '0, 0, 0, 0, 0, 1, 1, "R6");
    idle(2, "R6");

    // R5: reporting disabled, mismatch still sets dpe
    step(32'h0000_00FF, 4'h8, 0, 1, 1, 0, 0, 0, "R5");
    step('0, '0, 0, 0, 0, !nxt_good, 0, 0, "R5");
    idle(3, "R5");

    // R6: set and clear on the same edge -> set wins
    step('0, '0, 0, 0, 0, 0, 1, 1, "R6");
    step(32'h7777_0000, 4'h5, 0, 1, 1, 0, 1, 0, "R6");
    step('0, '0, 0, 0, 0, !nxt_good, 1, 0, "R6");
    step('0, '0, 0, 0, 0, 0, 1, 1, "R6");
    idle(2, "R6");
    step('0, '0, 0, 0, 0, 0, 1, 1, "R6");
    idle(2, "R6");

    // R7: idle edge and driven edge followed by bad parity -> nothing
    step(32'h1111_1111, 4'h1, 0, 1, 0, 0, 1, 0, "R7");
    step('0, '0, 0, 0, 0, !nxt_good, 1, 0, "R7");
    step(32'h2222_2222, 4'h6, 1, 1, 1, 0, 1, 0, "R7");
    step('0, '0, 0, 0, 0, !nxt_good, 1, 0, "R7");
    idle(3, "R7");

    // R9: back-to-back received phases, two bad, one good
    step(32'hCAFE_0001, 4'h9, 0, 1, 1, 0, 1, 0, "R9");
    step(32'hCAFE_0002, 4'hA, 0, 1, 1, !nxt_good, 1, 0, "R9");
    step(32'hCAFE_0003, 4'hB, 0, 1, 1, !nxt_good, 1, 0, "R9");
    step('0, '0, 0, 0, 0, nxt_good, 1, 0, "R9");
    idle(4, "R9");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule